// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a register-mapped general-purpose I/O controller for several ports of 32 pins each. The default build has three ports, 96 pins in all. A simple synchronous bus reaches it. Each access carries an enable, a write flag, a size flag (byte or word), a 14-bit byte address and 32 bits of write data. Read data comes back one cycle after the request.

For each pin the block drives an output value and an output enable. It samples each pad through a two-flop synchronizer.

Software can reach the pins in several ways:
- **Single-pin byte view:** one byte per pin.
- **Single-pin word view:** one word per pin.
- **Whole-port registers:** raw port value, direction, mask, and write-one set, clear and toggle.
- **Masked port view:** reads hide the masked bits, and writes leave the masked latch bits alone.

Whenever a pin's value is read, the result depends on its direction. An output pin returns its latch. An input pin returns the synchronized pad.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, pin_oe and pin_out are all zero, every mask register reads zero, and bus_rdata is zero.
- R2: The byte view of pin i (i = port*32 + bit) is at address i. A read returns 0x00000000 or 0x00000001. A write copies wdata bit 0 into the pin latch and ignores bits 31:1. Both sizes are accepted.
- R3: The word view of pin i is at 0x1000 + 4*i. A read returns 0x00000000 or 0xFFFFFFFF. A write of zero clears the latch and any nonzero value sets it. Only word-size accesses are decoded.
- R4: Direction register of port p is at 0x2000 + 4*p. Bit b = 1 makes pin_oe[p*32+b] high (output). It reads back as written.
- R5: The pin value is the latch for output pins and the synchronized pad for input pins. A pad change is not seen by a read sampled on the second rising edge after it, and is seen by a read sampled on the fourth.
- R6: Raw port register at 0x2100 + 4*p reads the 32 pin values and a write loads all 32 latch bits.
- R7: The set, clear and toggle registers are at 0x2200, 0x2280 and 0x2300 + 4*p. A 1 bit sets, clears or inverts that latch bit, and a 0 bit leaves it. All three read as zero.
- R8: Mask register at 0x2080 + 4*p reads back as written. The masked port register at 0x2180 + 4*p reads the pin values with every masked (1) bit forced to 0.
- R9: A write to the masked port register changes only latch bits whose mask bit is 0.
- R10: Any access outside the mapped set reads zero and leaves every register unchanged. This covers:
  - pin index of 96 or above;
  - port index of 3 or above;
  - addresses 0x3000 and up;
  - unused register groups;
  - a nonzero address bits 1:0 in word space;
  - byte-size access to word-view or register space.
- R11: bus_rdata carries the read result in the cycle after a read request, and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 1 = word access, 0 = byte access |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pin_in | input | 96 | Pad input values (asynchronous) |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enables (1 = driven) |

## Verification
The bench builds the block with its default values: three ports of 32 pins. With these values the last mapped pin (95) and the first unmapped pin index (96) can be reached in both single-pin views. So can the first missing port index (3) in register space. This lets the bench probe the edges of every decoded window, along with the third port's set, clear and toggle path and its word view.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 14;

    // address space selector, bus_addr[13:12]
    localparam logic [1:0] SPACE_BYTE = 2'd0;
    localparam logic [1:0] SPACE_WORD = 2'd1;
    localparam logic [1:0] SPACE_REG  = 2'd2;

    // register group selector, bus_addr[9:7]
    localparam logic [2:0] GRP_DIR   = 3'd0;
    localparam logic [2:0] GRP_MASK  = 3'd1;
    localparam logic [2:0] GRP_PORT  = 3'd2;
    localparam logic [2:0] GRP_MPORT = 3'd3;
    localparam logic [2:0] GRP_SET   = 3'd4;
    localparam logic [2:0] GRP_CLR   = 3'd5;
    localparam logic [2:0] GRP_TGL   = 3'd6;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_BYTE,
        ACC_WORD,
        ACC_DIR,
        ACC_MASK,
        ACC_PORT,
        ACC_MPORT,
        ACC_SET,
        ACC_CLR,
        ACC_TGL
    } acc_kind_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.s2;

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 32,
    localparam int unsigned PIX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int unsigned BIT_W    = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size_word,
    output acc_kind_e         kind,
    output logic [PIX_W-1:0]  port,
    output logic [BIT_W-1:0]  bitpos
);

    localparam int unsigned PIN_COUNT = NUM_PORTS * PORT_W;

    logic [11:0] pin_lin;
    logic        pin_hit;

    always_comb begin
        kind    = ACC_NONE;
        port    = '0;
        bitpos  = '0;
        pin_lin = '0;
        pin_hit = 1'b0;
        unique case (addr[13:12])
            SPACE_BYTE: begin
                if (32'(addr[11:0]) < PIN_COUNT) begin
                    pin_lin = addr[11:0];
                    pin_hit = 1'b1;
                    kind    = ACC_BYTE;
                end
            end
            SPACE_WORD: begin
                if (size_word && addr[1:0] == 2'b00 &&
                    32'(addr[11:2]) < PIN_COUNT) begin
                    pin_lin = {2'b00, addr[11:2]};
                    pin_hit = 1'b1;
                    kind    = ACC_WORD;
                end
            end
            SPACE_REG: begin
                if (size_word && addr[1:0] == 2'b00 && addr[11:10] == 2'b00 &&
                    32'(addr[6:2]) < NUM_PORTS) begin
                    port = PIX_W'(addr[6:2]);
                    unique case (addr[9:7])
                        GRP_DIR:   kind = ACC_DIR;
                        GRP_MASK:  kind = ACC_MASK;
                        GRP_PORT:  kind = ACC_PORT;
                        GRP_MPORT: kind = ACC_MPORT;
                        GRP_SET:   kind = ACC_SET;
                        GRP_CLR:   kind = ACC_CLR;
                        GRP_TGL:   kind = ACC_TGL;
                        default:   kind = ACC_NONE;
                    endcase
                end
            end
            default: kind = ACC_NONE;
        endcase
        if (pin_hit) begin
            port   = PIX_W'(32'(pin_lin) / PORT_W);
            bitpos = BIT_W'(32'(pin_lin) % PORT_W);
        end
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 32,
    localparam int unsigned PIX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int unsigned BIT_W    = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  acc_kind_e                         kind,
    input  logic [PIX_W-1:0]                  port,
    input  logic [BIT_W-1:0]                  bitpos,
    input  logic [BUS_W-1:0]                  wdata,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]  dir_q,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]  mask_q,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]  out_q
);

    typedef struct packed {
        logic [NUM_PORTS-1:0][PORT_W-1:0] dir;
        logic [NUM_PORTS-1:0][PORT_W-1:0] mask;
        logic [NUM_PORTS-1:0][PORT_W-1:0] out;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [PORT_W-1:0] wword;

    assign wword = wdata[PORT_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (kind)
                ACC_BYTE:  st_d.out[port][bitpos] = wdata[0];
                ACC_WORD:  st_d.out[port][bitpos] = |wdata;
                ACC_DIR:   st_d.dir[port]  = wword;
                ACC_MASK:  st_d.mask[port] = wword;
                ACC_PORT:  st_d.out[port]  = wword;
                ACC_MPORT: st_d.out[port]  = (st_q.out[port] & st_q.mask[port]) |
                                             (wword & ~st_q.mask[port]);
                ACC_SET:   st_d.out[port]  = st_q.out[port] | wword;
                ACC_CLR:   st_d.out[port]  = st_q.out[port] & ~wword;
                ACC_TGL:   st_d.out[port]  = st_q.out[port] ^ wword;
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q  = st_q.dir;
    assign mask_q = st_q.mask;
    assign out_q  = st_q.out;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 32,
    localparam int unsigned PIN_COUNT = NUM_PORTS * PORT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic                 bus_size,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);

    localparam int unsigned PIX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int unsigned BIT_W = (PORT_W > 1) ? $clog2(PORT_W) : 1;

    acc_kind_e                        kind;
    logic [PIX_W-1:0]                 port;
    logic [BIT_W-1:0]                 bitpos;
    logic [NUM_PORTS-1:0][PORT_W-1:0] dir_q, mask_q, out_q, pad_sync, pin_val;
    logic [BUS_W-1:0]                 rdata_d, rdata_q;

    gpio_addr_dec #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_dec (
        .addr      (bus_addr),
        .size_word (bus_size),
        .kind      (kind),
        .port      (port),
        .bitpos    (bitpos)
    );

    gpio_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_en && bus_we),
        .kind   (kind),
        .port   (port),
        .bitpos (bitpos),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .mask_q (mask_q),
        .out_q  (out_q)
    );

    gpio_sync #(.W(PIN_COUNT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pad_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pinval
        assign pin_val[p] = (dir_q[p] & out_q[p]) | (~dir_q[p] & pad_sync[p]);
    end

    always_comb begin
        rdata_d = '0;
        if (bus_en && !bus_we) begin
            unique case (kind)
                ACC_BYTE:  rdata_d[0] = pin_val[port][bitpos];
                ACC_WORD:  rdata_d = {BUS_W{pin_val[port][bitpos]}};
                ACC_DIR:   rdata_d = BUS_W'(dir_q[port]);
                ACC_MASK:  rdata_d = BUS_W'(mask_q[port]);
                ACC_PORT:  rdata_d = BUS_W'(pin_val[port]);
                ACC_MPORT: rdata_d = BUS_W'(pin_val[port] & ~mask_q[port]);
                default:   rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = out_q;
    assign pin_oe    = dir_q;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 32,
    localparam int unsigned PIN_COUNT = NUM_PORTS * PORT_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_en,
    input logic                 bus_we,
    input logic                 bus_size,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe
);

    logic rd, wr;
    assign rd = bus_en && !bus_we;
    assign wr = bus_en && bus_we;

    AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_size && bus_addr == 14'h2000) |=>
        pin_oe[PORT_W-1:0] == $past(bus_wdata[PORT_W-1:0])); // R4

    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_size && bus_addr == 14'h2200) |=>
        pin_out[PORT_W-1:0] == ($past(pin_out[PORT_W-1:0]) | $past(bus_wdata[PORT_W-1:0]))); // R7

    AST_CLR_ANDN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_size && bus_addr == 14'h2280) |=>
        pin_out[PORT_W-1:0] == ($past(pin_out[PORT_W-1:0]) & ~$past(bus_wdata[PORT_W-1:0]))); // R7

    AST_TGL_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_size && bus_addr == 14'h2300) |=>
        pin_out[PORT_W-1:0] == ($past(pin_out[PORT_W-1:0]) ^ $past(bus_wdata[PORT_W-1:0]))); // R7

    AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 14'h2200) |=> bus_rdata == '0); // R7

    AST_BYTE_VIEW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && 32'(bus_addr) < PIN_COUNT) |=> bus_rdata[BUS_W-1:1] == '0); // R2

    AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[13:12] == 2'b11) |=> bus_rdata == '0); // R10

    AST_UNMAPPED_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr[13:12] == 2'b11) |=> ($stable(pin_out) && $stable(pin_oe))); // R10

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> bus_rdata == '0); // R11

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_size = 1'b1;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:0] pin_in = '0;
    logic [95:0] pin_out, pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpio_port_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d, input logic sz);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, input logic sz, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 oe[31:0]",  pin_oe[31:0],  32'h0);
        chk("R1 oe[95:64]", pin_oe[95:64], 32'h0);
        chk("R1 out[63:32]", pin_out[63:32], 32'h0);
        chk("R1 rdata idle", bus_rdata, 32'h0);
        rd(14'h2088, 1'b1, v);
        chk("R1 mask2", v, 32'h0);
        @(negedge clk);
        chk("R11 rdata zero after read", bus_rdata, 32'h0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(14'h2004, 32'hA5A5_0F0F, 1'b1);
        chk("R4 oe port1", pin_oe[63:32], 32'hA5A5_0F0F);
        chk("R4 oe port0 untouched", pin_oe[31:0], 32'h0);
        rd(14'h2004, 1'b1, v);
        chk("R4 dir readback", v, 32'hA5A5_0F0F);
    endtask

    task automatic t_byte();
        logic [31:0] v;
        // pin 40 = port1 bit8, an output after t_dir
        wr(14'd40, 32'hFFFF_FFFE, 1'b0);
        chk("R2 bit0=0 high bits ignored", 32'(pin_out[40]), 32'h0);
        wr(14'd40, 32'h0000_0003, 1'b0);
        chk("R2 byte set", 32'(pin_out[40]), 32'h1);
        rd(14'd40, 1'b0, v);
        chk("R2 byte read one", v, 32'h1);
        wr(14'd40, 32'h0000_00FE, 1'b1);
        chk("R2 word-size clear", 32'(pin_out[40]), 32'h0);
        rd(14'd40, 1'b1, v);
        chk("R2 byte read zero", v, 32'h0);
        wr(14'd95, 32'h1, 1'b0);
        chk("R2 last pin", 32'(pin_out[95]), 32'h1);
        wr(14'd96, 32'h1, 1'b0);
        chk("R10 pin 96 unmapped", pin_out[95:64], 32'h8000_0000);
        wr(14'd95, 32'h0, 1'b0);
    endtask

    task automatic t_word();
        logic [31:0] v;
        wr(14'h2008, 32'hFFFF_FFFF, 1'b1);
        wr(14'h1118, 32'h0000_0100, 1'b1);          // pin 70
        chk("R3 nonzero sets", pin_out[95:64], 32'h0000_0040);
        rd(14'h1118, 1'b1, v);
        chk("R3 read all ones", v, 32'hFFFF_FFFF);
        wr(14'h1118, 32'h0, 1'b0);
        chk("R10 byte-size to word view ignored", pin_out[95:64], 32'h0000_0040);
        wr(14'h1118, 32'h0, 1'b1);
        chk("R3 zero clears", pin_out[95:64], 32'h0);
        rd(14'h1118, 1'b1, v);
        chk("R3 read all zeros", v, 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] v;
        pin_in[31:0] = 32'hCAFE_F00D;
        wr(14'h2100, 32'h1234_5678, 1'b1);
        chk("R6 raw write latch", pin_out[31:0], 32'h1234_5678);
        repeat (3) @(negedge clk);
        rd(14'h2100, 1'b1, v);
        chk("R5 input pins read pad", v, 32'hCAFE_F00D);
        wr(14'h2000, 32'hFFFF_0000, 1'b1);
        rd(14'h2100, 1'b1, v);
        chk("R5 mixed dir read", v, 32'h1234_F00D);
    endtask

    task automatic t_sct();
        logic [31:0] v;
        wr(14'h2108, 32'h0000_FFFF, 1'b1);
        wr(14'h2208, 32'hFF00_0000, 1'b1);
        chk("R7 set", pin_out[95:64], 32'hFF00_FFFF);
        wr(14'h2288, 32'h0000_00F0, 1'b1);
        chk("R7 clear", pin_out[95:64], 32'hFF00_FF0F);
        wr(14'h2308, 32'h0F0F_0F0F, 1'b1);
        chk("R7 toggle", pin_out[95:64], 32'hF00F_F000);
        rd(14'h2208, 1'b1, v);
        chk("R7 set reads zero", v, 32'h0);
        rd(14'h2308, 1'b1, v);
        chk("R7 toggle reads zero", v, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(14'h2084, 32'hFFFF_0000, 1'b1);
        rd(14'h2084, 1'b1, v);
        chk("R8 mask readback", v, 32'hFFFF_0000);
        wr(14'h2004, 32'hFFFF_FFFF, 1'b1);
        wr(14'h2104, 32'h1111_2222, 1'b1);
        rd(14'h2184, 1'b1, v);
        chk("R8 masked read", v, 32'h0000_2222);
        wr(14'h2184, 32'hAAAA_BBBB, 1'b1);
        chk("R9 masked write", pin_out[63:32], 32'h1111_BBBB);
        rd(14'h2104, 1'b1, v);
        chk("R6 raw read ignores mask", v, 32'h1111_BBBB);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        // port0 bits 15:0 are inputs, pad currently 0xF00D
        @(negedge clk);
        pin_in[3:0] = 4'h2;                          // 0xF00D -> 0xF002
        rd(14'h2100, 1'b1, v);                       // sampled on 2nd edge
        chk("R5 early read sees old pad", v, 32'h1234_F00D);
        rd(14'h2100, 1'b1, v);                       // sampled on 4th edge
        chk("R5 later read sees new pad", v, 32'h1234_F002);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(14'h3000, 1'b1, v);
        chk("R10 read 0x3000", v, 32'h0);
        wr(14'h200C, 32'hFFFF_FFFF, 1'b1);
        chk("R10 port3 dir ignored", pin_oe[95:64], 32'hFFFF_FFFF);
        wr(14'h2000, 32'h0, 1'b0);
        chk("R10 byte-size dir ignored", pin_oe[31:0], 32'hFFFF_0000);
        wr(14'h2101, 32'h0, 1'b1);
        chk("R10 misaligned port ignored", pin_out[31:0], 32'h1234_5678);
        wr(14'h2380, 32'hFFFF_FFFF, 1'b1);
        chk("R10 unused group", pin_out[31:0], 32'h1234_5678);
        rd(14'h2380, 1'b1, v);
        chk("R10 unused group reads zero", v, 32'h0);
        rd(14'h200C, 1'b1, v);
        chk("R10 port3 reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir();
        t_byte();
        t_word();
        t_raw();
        t_sct();
        t_mask();
        t_sync();
        t_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule